// File: doc/BRIEF.md
# Barrel-Thread Pin Framer

A single fast core that issues one instruction from each of its threads in strict rotation can be made to look, at its pins, exactly like a set of slower cores running side by side. This block supplies that pin discipline. Time is divided into frames. A frame holds one issue slot per thread, and every slot is the same fixed number of clocks long. The block walks the slot index, latches all input pins once when a frame begins so that every thread reads the same picture for the whole frame, and collects each thread's output and drive-enable writes in a private shadow. At the frame boundary it moves the merged shadow onto the real pins in one step.

Several threads may change pins in the same frame. Their edges then appear together at the boundary, as they would from parallel cores. A slot whose thread is not live still takes up its clocks and is treated as a no-op. Where threads overlap on a pin, the pin is the OR of their driven values, and a pin is driven when any thread enables it.

Top module: `barrel_io_framer`

## Requirements
- R1: While reset is asserted and right after it, `pin_oe` and `pin_out` are all zero, `frame_strobe` is 0, `snap` is 0, and `slot_idx` reads NUM_THREADS-1, meaning the position just before a frame.
- R2: The first clock edge after reset starts frame 0 with `slot_idx` = 0. From there `slot_idx` holds for SLOT_CLKS clocks, then adds one. After NUM_THREADS-1 it returns to 0, so a frame is NUM_THREADS*SLOT_CLKS clocks long.
- R3: `snap` takes the value `pin_in` had in the last clock before a frame begins. It is the same in every clock of that frame, however `pin_in` moves.
- R4: `pin_out` and `pin_oe` change only in a clock where `frame_strobe` is 1. `frame_strobe` is 1 for exactly one clock, the first clock of each frame after frame 0. The first commit therefore lands at the end of the first complete frame, so any pin changes at most once per frame.
- R5: When `wr_valid` is 1 in any clock of slot t and thread t is live, the thread's shadow output and shadow enable take `wr_val` and `wr_oe`. The pins show them from the next frame start, and this includes a write made in the last clock of a frame.
- R6: A write made in the slot of a thread whose `thread_live` bit is 0 changes nothing.
- R7: At each commit, `pin_oe` bit b is the OR of bit b of all thread enables. `pin_out` bit b is the OR over threads of output AND enable, so a bit that no thread drives reads 0.
- R8: A thread's shadow keeps its value across frames until that thread writes again, so with no writes the pins keep their values across commits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| thread_live | input | NUM_THREADS | Bit t set: thread t is live and its writes count |
| wr_valid | input | 1 | Write from the thread that owns the current slot |
| wr_val | input | PIN_W | Output levels written by that thread |
| wr_oe | input | PIN_W | Drive enables written by that thread |
| pin_in | input | PIN_W | Raw input pins |
| snap | output | PIN_W | Input sample for the current frame |
| pin_out | output | PIN_W | Committed pin levels |
| pin_oe | output | PIN_W | Committed drive enables |
| slot_idx | output | $clog2(NUM_THREADS) | Thread that owns the current slot |
| frame_strobe | output | 1 | One-clock pulse in the clock the pins take new values |

## Verification
Two pairs of events can fall in the same clock edge. The first is a thread write and the frame commit: the last thread writes in the very last clock of every frame, and the bench expects that write on the pins at the next frame start. The second is the input capture and a change of `pin_in`: the bench alters `pin_in` every clock and puts the value it expects into `pin_in` only in the last clock of the frame. It then judges `snap` against that value in every clock of the following frame, while checking at the same time that the pins and the strobe stay quiet between boundaries.

// File: rtl/bif_pkg.sv
package bif_pkg;

    // Frame events raised by the slot sequencer for the pin stage.
    typedef struct packed {
        logic capture;   // boundary edge: sample inputs
        logic commit;    // boundary edge after a full frame: drive pins
    } bif_evt_t;

endpackage

// File: rtl/bif_slot_seq.sv
module bif_slot_seq
    import bif_pkg::*;
#(
    parameter int NUM_THREADS = 8,
    parameter int SLOT_CLKS   = 2,
    localparam int TW = $clog2(NUM_THREADS),
    localparam int CW = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] slot,
    output bif_evt_t      evt
);

    typedef struct packed {
        logic [CW-1:0] cyc;
        logic [TW-1:0] slot;
        logic          primed;
    } seq_t;

    seq_t s_d, s_q;
    logic last_cyc;
    logic bnd;

    always_comb begin
        s_d      = s_q;
        last_cyc = (s_q.cyc == CW'(SLOT_CLKS - 1));
        bnd      = last_cyc && (s_q.slot == TW'(NUM_THREADS - 1));
        if (last_cyc) begin
            s_d.cyc  = '0;
            s_d.slot = bnd ? '0 : s_q.slot + TW'(1);
        end else begin
            s_d.cyc  = s_q.cyc + CW'(1);
        end
        s_d.primed  = s_q.primed | bnd;
        evt.capture = bnd;
        evt.commit  = bnd & s_q.primed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cyc    <= CW'(SLOT_CLKS - 1);
            s_q.slot   <= TW'(NUM_THREADS - 1);
            s_q.primed <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign slot = s_q.slot;

    // R2
    slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt.capture |=> (slot == '0));

    // R2
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !last_cyc |=> $stable(slot));

endmodule

// File: rtl/bif_shadow_bank.sv
module bif_shadow_bank #(
    parameter int NUM_THREADS = 8,
    parameter int PIN_W       = 8,
    localparam int TW = $clog2(NUM_THREADS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [TW-1:0]          slot,
    input  logic [NUM_THREADS-1:0] live,
    input  logic                   wr_valid,
    input  logic [PIN_W-1:0]       wr_val,
    input  logic [PIN_W-1:0]       wr_oe,
    output logic [PIN_W-1:0]       nxt_out,
    output logic [PIN_W-1:0]       nxt_oe
);

    typedef struct packed {
        logic [NUM_THREADS-1:0][PIN_W-1:0] out;
        logic [NUM_THREADS-1:0][PIN_W-1:0] oe;
    } bank_t;

    bank_t b_d, b_q;
    logic [NUM_THREADS-1:0] sel;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        assign sel[t] = wr_valid && live[t] && (slot == TW'(t));

        // R6
        shadow_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !sel[t] |=> ($stable(b_q.out[t]) && $stable(b_q.oe[t])));
    end

    always_comb begin
        b_d     = b_q;
        nxt_out = '0;
        nxt_oe  = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (sel[t]) begin
                b_d.out[t] = wr_val;
                b_d.oe[t]  = wr_oe;
            end
        end
        for (int t = 0; t < NUM_THREADS; t++) begin
            nxt_oe  = nxt_oe | b_d.oe[t];
            nxt_out = nxt_out | (b_d.out[t] & b_d.oe[t]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    // R5
    one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

endmodule

// File: rtl/bif_pin_commit.sv
module bif_pin_commit
    import bif_pkg::*;
#(
    parameter int PIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bif_evt_t         evt,
    input  logic [PIN_W-1:0] pin_in,
    input  logic [PIN_W-1:0] nxt_out,
    input  logic [PIN_W-1:0] nxt_oe,
    output logic [PIN_W-1:0] snap,
    output logic [PIN_W-1:0] pin_out,
    output logic [PIN_W-1:0] pin_oe,
    output logic             frame_strobe
);

    typedef struct packed {
        logic [PIN_W-1:0] snap;
        logic [PIN_W-1:0] out;
        logic [PIN_W-1:0] oe;
        logic             strobe;
    } pin_t;

    pin_t p_d, p_q;

    always_comb begin
        p_d        = p_q;
        p_d.strobe = evt.commit;
        if (evt.capture) p_d.snap = pin_in;
        if (evt.commit) begin
            p_d.out = nxt_out;
            p_d.oe  = nxt_oe;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign snap         = p_q.snap;
    assign pin_out      = p_q.out;
    assign pin_oe       = p_q.oe;
    assign frame_strobe = p_q.strobe;

    // R3
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt.capture |=> $stable(snap));

    // R4
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |-> ($stable(pin_out) && $stable(pin_oe)));

    // R4
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |=> !frame_strobe);

    // R7
    undriven_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

endmodule

// File: rtl/barrel_io_framer.sv
module barrel_io_framer
    import bif_pkg::*;
#(
    parameter int NUM_THREADS = 8,
    parameter int PIN_W       = 8,
    parameter int SLOT_CLKS   = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_THREADS-1:0]         thread_live,
    input  logic                           wr_valid,
    input  logic [PIN_W-1:0]               wr_val,
    input  logic [PIN_W-1:0]               wr_oe,
    input  logic [PIN_W-1:0]               pin_in,
    output logic [PIN_W-1:0]               snap,
    output logic [PIN_W-1:0]               pin_out,
    output logic [PIN_W-1:0]               pin_oe,
    output logic [$clog2(NUM_THREADS)-1:0] slot_idx,
    output logic                           frame_strobe
);

    localparam int TW = $clog2(NUM_THREADS);

    logic [TW-1:0]    slot_w;
    bif_evt_t         evt_w;
    logic [PIN_W-1:0] nxt_out_w;
    logic [PIN_W-1:0] nxt_oe_w;

    bif_slot_seq #(
        .NUM_THREADS(NUM_THREADS),
        .SLOT_CLKS  (SLOT_CLKS)
    ) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .slot (slot_w),
        .evt  (evt_w)
    );

    bif_shadow_bank #(
        .NUM_THREADS(NUM_THREADS),
        .PIN_W      (PIN_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot    (slot_w),
        .live    (thread_live),
        .wr_valid(wr_valid),
        .wr_val  (wr_val),
        .wr_oe   (wr_oe),
        .nxt_out (nxt_out_w),
        .nxt_oe  (nxt_oe_w)
    );

    bif_pin_commit #(
        .PIN_W(PIN_W)
    ) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt_w),
        .pin_in      (pin_in),
        .nxt_out     (nxt_out_w),
        .nxt_oe      (nxt_oe_w),
        .snap        (snap),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .frame_strobe(frame_strobe)
    );

    assign slot_idx = slot_w;

endmodule

// File: tb/barrel_io_framer_tb.sv
module barrel_io_framer_tb;

    localparam int NT = 8;
    localparam int PW = 8;
    localparam int SC = 2;

    // Vector fields: {live mask, write mask, pin_in at boundary, value seed}
    localparam int NV = 6;
    localparam logic [31:0] VEC [NV] = '{
        32'hFF_FF_3C_5A,   // all live, all write
        32'h0F_FF_C3_A7,   // upper four threads not live
        32'hFF_00_55_00,   // no writes: pins persist
        32'h01_01_AA_FF,   // single thread writes
        32'hFF_81_0F_33,   // first and last thread write
        32'hF0_FF_F0_1E    // lower four threads not live
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] thread_live = '0;
    logic          wr_valid = 1'b0;
    logic [PW-1:0] wr_val = '0;
    logic [PW-1:0] wr_oe = '0;
    logic [PW-1:0] pin_in = '0;
    logic [PW-1:0] snap, pin_out, pin_oe;
    logic [2:0]    slot_idx;
    logic          frame_strobe;

    int n_chk = 0;
    int n_bad = 0;

    logic [PW-1:0] sh_out [NT];
    logic [PW-1:0] sh_oe  [NT];
    logic [PW-1:0] exp_out, exp_oe, exp_snap;

    always #4 clk = ~clk;

    barrel_io_framer #(.NUM_THREADS(NT), .PIN_W(PW), .SLOT_CLKS(SC)) u_dut (
        .clk(clk), .rst_n(rst_n), .thread_live(thread_live),
        .wr_valid(wr_valid), .wr_val(wr_val), .wr_oe(wr_oe),
        .pin_in(pin_in), .snap(snap), .pin_out(pin_out), .pin_oe(pin_oe),
        .slot_idx(slot_idx), .frame_strobe(frame_strobe)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] val_out(input logic [7:0] seed, input int t);
        return seed + 8'(t * 29);
    endfunction

    function automatic logic [7:0] val_oe(input logic [7:0] seed, input int t);
        return {seed[3:0], seed[7:4]} ^ 8'(8'h11 << (t % 4)) ^ 8'(t);
    endfunction

    task automatic model_clear();
        for (int t = 0; t < NT; t++) begin
            sh_out[t] = '0;
            sh_oe[t]  = '0;
        end
    endtask

    task automatic model_commit();
        exp_out = '0;
        exp_oe  = '0;
        for (int t = 0; t < NT; t++) begin
            exp_oe  = exp_oe | sh_oe[t];
            exp_out = exp_out | (sh_out[t] & sh_oe[t]);
        end
    endtask

    // Checks made in the first clock of a frame.
    task automatic frame_start_check(input bit first);
        check8("R4 strobe at frame start", {7'd0, frame_strobe}, first ? 8'd0 : 8'd1);
        check8("R7 pin_out at commit", pin_out, exp_out);
        check8("R7 pin_oe at commit", pin_oe, exp_oe);
        check8("R3 snap at frame start", snap, exp_snap);
        check8("R2 slot at frame start", {5'd0, slot_idx}, 8'd0);
    endtask

    task automatic run_frame(input logic [31:0] v, input bit first);
        logic [7:0] live, wmask, pv, seed;
        {live, wmask, pv, seed} = v;
        thread_live = live;
        for (int t = 0; t < NT; t++) begin
            for (int c = 0; c < SC; c++) begin
                if (t == 0 && c == 0) begin
                    frame_start_check(first);
                end else begin
                    check8("R4 no strobe mid-frame", {7'd0, frame_strobe}, 8'd0);
                    check8("R4 pin_out held mid-frame", pin_out, exp_out);
                    check8("R4 pin_oe held mid-frame", pin_oe, exp_oe);
                    check8("R3 snap held mid-frame", snap, exp_snap);
                end
                check8("R2 slot index", {5'd0, slot_idx}, 8'(t));
                wr_valid = (c == SC - 1) && wmask[t];
                wr_val   = val_out(seed, t);
                wr_oe    = val_oe(seed, t);
                pin_in   = (t == NT - 1 && c == SC - 1) ? pv : pv ^ 8'(t * 16 + c + 1);
                step();
                if (wr_valid && live[t]) begin   // R5, R6
                    sh_out[t] = val_out(seed, t);
                    sh_oe[t]  = val_oe(seed, t);
                end
            end
        end
        wr_valid = 1'b0;
        model_commit();   // R8: untouched shadows carry over
        exp_snap = pv;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        model_clear();
        exp_out  = '0;
        exp_oe   = '0;
        pin_in   = 8'hA5;
        repeat (3) @(negedge clk);
        // R1: reset state
        check8("R1 pin_oe in reset", pin_oe, 8'h00);
        check8("R1 pin_out in reset", pin_out, 8'h00);
        check8("R1 strobe in reset", {7'd0, frame_strobe}, 8'd0);
        check8("R1 snap in reset", snap, 8'h00);
        check8("R1 slot in reset", {5'd0, slot_idx}, 8'(NT - 1));
        rst_n = 1'b1;
        step();                       // priming edge captures 0xA5
        exp_snap = 8'hA5;

        // R2, R4: frame 0 brings no strobe; first commit after it
        for (int i = 0; i < NV; i++) begin
            run_frame(VEC[i], i == 0);
        end
        frame_start_check(1'b0);

        // R8: a frame with no writes keeps every pin
        run_frame(32'hFF_00_99_00, 1'b0);
        frame_start_check(1'b0);

        // R5: only the last thread writes, in the last clock of the frame
        run_frame(32'hFF_80_42_C8, 1'b0);
        frame_start_check(1'b0);

        // R1: reset in the middle of a frame returns the pins to idle
        run_frame(32'hFF_FF_17_61, 1'b0);
        repeat (5) step();
        rst_n = 1'b0;
        @(negedge clk);
        check8("R1 pin_oe after mid-run reset", pin_oe, 8'h00);
        check8("R1 pin_out after mid-run reset", pin_out, 8'h00);
        check8("R1 slot after mid-run reset", {5'd0, slot_idx}, 8'(NT - 1));
        pin_in = 8'h3E;
        rst_n  = 1'b1;
        step();
        model_clear();
        exp_out  = '0;
        exp_oe   = '0;
        exp_snap = 8'h3E;
        run_frame(32'hFF_FF_E1_4D, 1'b1);
        frame_start_check(1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule